// File: doc/BRIEF.md
# Sector Bit-Error Corrector

This block takes a list of bit-error positions for one 512-byte sector and repairs the sector in place. The sector sits in an external 512x8 buffer with a one-cycle read latency. The positions come from a separate error locator and are given all at once, with a start strobe. The block works through the list one entry at a time. For each entry that falls in the data part of the codeword, it reads the affected byte, flips one bit and writes the byte back.

Positions count from the end of the codeword, and the parity bits come first. A position below the parity length names a parity bit and leaves the sector unchanged. A data position is first reduced by the parity length and then mirrored into a byte address and a bit within that byte. The selected strength sets the parity length. Before any entry is used, the stored parity bytes are checked. A sector whose parity bytes read as erased is reported clean and is never touched.

A controller fills the buffer, pulses start and waits for the done pulse. It then reads the erased and overflow flags, which stay valid until the next start.

Top module: `bch_sector_fixer`

## Requirements
- R1: After reset, busy, done, erased and overflow are 0, and neither buffer strobe is asserted while busy is 0.
- R2: Strength code 0 gives 52 parity bits, code 1 gives 104 and code 2 gives 208. Code 3 behaves as code 1.
- R3: A location below the parity bit count causes no buffer access and leaves the sector unchanged.
- R4: A data location L gives adj = L - P, where P is the parity bit count. The byte at address (4095 - adj) / 8 is read. In the next cycle the same address is written with the read byte XOR (1 << (adj mod 8)).
- R5: Parity bytes arrive on a flat bus, byte k on bits [8k+7:8k]. The stored byte count is 8, 14 or 26 for strength codes 0, 1 and 2 (code 3 uses 14). If every stored byte except the last equals 0xFF, the sector is erased: the buffer is not accessed and erased is 1 at done.
- R6: List entries are used in list order, entry k on bits [13k+12:13k]. A skipped entry takes one cycle and a data entry takes two. Done is a one-cycle pulse in the cycle after the last entry, so it is first seen 1 + n cycles after the start edge, where n is the sum of those cycle counts.
- R7: An error count above 8 is clamped to 8 and sets overflow at done. A count of 8 or less clears overflow.
- R8: A start pulse while busy is ignored: no extra accesses and no extra done pulse.
- R9: A location at or beyond P + 4096 lies outside the codeword and is skipped like a parity location.
- R10: An error count of zero gives done in the cycle after the start edge, with no buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| err_count_i | input | 4 | Number of valid list entries |
| err_locs_i | input | 104 | Error location list, 8 entries of 13 bits |
| strength_i | input | 2 | Correction strength code |
| parity_i | input | 208 | Stored parity bytes of the sector |
| buf_addr_o | output | 9 | Buffer byte address |
| buf_rd_en_o | output | 1 | Buffer read strobe (data returns next cycle) |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| erased_o | output | 1 | Last job saw an erased sector |
| overflow_o | output | 1 | Last job had its error count clamped |

## Verification
A wrong list index or a wrong entry limit shows up in two places. The order of the buffer read addresses changes, and done arrives on a cycle other than 1 + n after start, so the fault is visible within a few cycles of the job. A mask or address fault in the position conversion flips the wrong bit, which shows up when the whole buffer is compared after done. A wrong erased or overflow latch shows at done, either as a flag value or as buffer accesses that should not happen. A sequencer that re-arms while busy shows up as extra reads or a second done pulse in the quiet window after completion.

// File: rtl/bch_fix_pkg.sv
`timescale 1ns/1ps
package bch_fix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } fix_state_e;

  // Parity length in bits for a strength code; code 3 falls back to the middle strength.
  function automatic logic [7:0] parity_bit_len(input logic [1:0] code);
    case (code)
      2'd0:    parity_bit_len = 8'd52;
      2'd2:    parity_bit_len = 8'd208;
      default: parity_bit_len = 8'd104;
    endcase
  endfunction

  // Number of parity bytes kept in the spare area for a strength code.
  function automatic logic [5:0] parity_byte_len(input logic [1:0] code);
    case (code)
      2'd0:    parity_byte_len = 6'd8;
      2'd2:    parity_byte_len = 6'd26;
      default: parity_byte_len = 6'd14;
    endcase
  endfunction

endpackage

// File: rtl/bch_loc_decode.sv
`timescale 1ns/1ps
module bch_loc_decode
  import bch_fix_pkg::*;
#(
  parameter int LOC_W     = 13,
  parameter int DATA_BITS = 4096,
  parameter int ADDR_W    = 9
) (
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [1:0]        strength_i,
  output logic              in_data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        mask_o
);

  logic [LOC_W-1:0] pbits;
  logic [LOC_W-1:0] adj;
  logic [LOC_W-1:0] mirrored;
  logic             above_parity;
  logic             inside_data;

  always_comb begin
    pbits        = LOC_W'(parity_bit_len(strength_i));
    above_parity = (loc_i >= pbits);
    adj          = loc_i - pbits;
    inside_data  = (adj < LOC_W'(DATA_BITS));
    mirrored     = LOC_W'(DATA_BITS - 1) - adj;
    in_data_o    = above_parity && inside_data;
    addr_o       = mirrored[ADDR_W+2:3];
    mask_o       = 8'd1 << adj[2:0];
  end

endmodule

// File: rtl/bch_erase_detect.sv
`timescale 1ns/1ps
module bch_erase_detect
  import bch_fix_pkg::*;
#(
  parameter int PAR_BYTES = 26
) (
  input  logic [PAR_BYTES*8-1:0] parity_i,
  input  logic [1:0]             strength_i,
  output logic                   erased_o
);

  logic [5:0]           checked_len;
  logic [PAR_BYTES-1:0] byte_ok;

  assign checked_len = parity_byte_len(strength_i) - 6'd1;

  // A byte passes if it reads 0xFF or lies outside the checked range.
  for (genvar k = 0; k < PAR_BYTES; k++) begin : g_byte
    assign byte_ok[k] = (parity_i[k*8 +: 8] == 8'hFF) || (6'(k) >= checked_len);
  end

  assign erased_o = &byte_ok;

endmodule

// File: rtl/bch_fix_seq.sv
`timescale 1ns/1ps
module bch_fix_seq
  import bch_fix_pkg::*;
#(
  parameter int MAX_ERR = 8,
  parameter int LOC_W   = 13,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         err_count_i,
  input  logic [MAX_ERR*LOC_W-1:0] err_locs_i,
  input  logic [1:0]               strength_i,
  input  logic                     erased_i,
  output logic [LOC_W-1:0]         cur_loc_o,
  output logic [1:0]               str_o,
  input  logic                     dec_in_data_i,
  input  logic [ADDR_W-1:0]        dec_addr_i,
  input  logic [7:0]               dec_mask_i,
  output logic [ADDR_W-1:0]        buf_addr_o,
  output logic                     buf_rd_en_o,
  input  logic [7:0]               buf_rdata_i,
  output logic                     buf_wr_en_o,
  output logic [7:0]               buf_wdata_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     erased_o,
  output logic                     overflow_o
);

  localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  fix_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [1:0]        str_q, str_d;
  logic              erased_q, erased_d;
  logic              ovf_q, ovf_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        mask_q;
  logic [LOC_W-1:0]  locs_q [MAX_ERR];
  logic              load_en;
  logic              cap_en;
  logic              too_many;
  logic [CNT_W-1:0]  cnt_clamped;
  logic              at_last;

  assign too_many    = (err_count_i > CNT_W'(MAX_ERR));
  assign cnt_clamped = too_many ? CNT_W'(MAX_ERR) : err_count_i;
  assign at_last     = (idx_q == last_q);

  // Next-state and output decode
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    last_d      = last_q;
    str_d       = str_q;
    erased_d    = erased_q;
    ovf_d       = ovf_q;
    load_en     = 1'b0;
    cap_en      = 1'b0;
    buf_rd_en_o = 1'b0;
    buf_wr_en_o = 1'b0;
    buf_addr_o  = addr_q;
    done_o      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en  = 1'b1;
          str_d    = strength_i;
          erased_d = erased_i;
          ovf_d    = too_many;
          idx_d    = '0;
          last_d   = IDX_W'(cnt_clamped - CNT_W'(1));
          state_d  = (erased_i || (err_count_i == '0)) ? ST_FIN : ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (dec_in_data_i) begin
          buf_rd_en_o = 1'b1;
          buf_addr_o  = dec_addr_i;
          cap_en      = 1'b1;
          state_d     = ST_WRITE;
        end else if (at_last) begin
          state_d = ST_FIN;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_WRITE: begin
        buf_wr_en_o = 1'b1;
        if (at_last) begin
          state_d = ST_FIN;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = ST_SCAN;
        end
      end
      ST_FIN: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      str_q    <= '0;
      erased_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      str_q    <= str_d;
      erased_q <= erased_d;
      ovf_q    <= ovf_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= '0;
    end else begin
      if (cap_en) begin
        addr_q <= dec_addr_i;
        mask_q <= dec_mask_i;
      end
      if (load_en) begin
        for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= err_locs_i[k*LOC_W +: LOC_W];
      end
    end
  end

  assign cur_loc_o   = locs_q[idx_q];
  assign str_o       = str_q;
  assign buf_wdata_o = buf_rdata_i ^ mask_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign erased_o    = erased_q;
  assign overflow_o  = ovf_q;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en_o |-> ($past(buf_rd_en_o) && (buf_addr_o == $past(buf_addr_o))));

  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en_o && buf_wr_en_o));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!buf_rd_en_o && !buf_wr_en_o && !done_o));

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_q);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(last_q) && $stable(str_q) && $stable(ovf_q)));

endmodule

// File: rtl/bch_sector_fixer.sv
`timescale 1ns/1ps
module bch_sector_fixer
  import bch_fix_pkg::*;
#(
  parameter int MAX_ERR   = 8,
  parameter int LOC_W     = 13,
  parameter int CNT_W     = 4,
  parameter int DATA_BITS = 4096,
  parameter int PAR_BYTES = 26,
  localparam int ADDR_W   = $clog2(DATA_BITS / 8)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         err_count_i,
  input  logic [MAX_ERR*LOC_W-1:0] err_locs_i,
  input  logic [1:0]               strength_i,
  input  logic [PAR_BYTES*8-1:0]   parity_i,
  output logic [ADDR_W-1:0]        buf_addr_o,
  output logic                     buf_rd_en_o,
  input  logic [7:0]               buf_rdata_i,
  output logic                     buf_wr_en_o,
  output logic [7:0]               buf_wdata_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     erased_o,
  output logic                     overflow_o
);

  logic              erased_now;
  logic [LOC_W-1:0]  cur_loc;
  logic [1:0]        cur_str;
  logic              dec_in_data;
  logic [ADDR_W-1:0] dec_addr;
  logic [7:0]        dec_mask;

  bch_erase_detect #(.PAR_BYTES(PAR_BYTES)) u_erase (
    .parity_i   (parity_i),
    .strength_i (strength_i),
    .erased_o   (erased_now)
  );

  bch_loc_decode #(.LOC_W(LOC_W), .DATA_BITS(DATA_BITS), .ADDR_W(ADDR_W)) u_decode (
    .loc_i      (cur_loc),
    .strength_i (cur_str),
    .in_data_o  (dec_in_data),
    .addr_o     (dec_addr),
    .mask_o     (dec_mask)
  );

  bch_fix_seq #(.MAX_ERR(MAX_ERR), .LOC_W(LOC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .err_count_i   (err_count_i),
    .err_locs_i    (err_locs_i),
    .strength_i    (strength_i),
    .erased_i      (erased_now),
    .cur_loc_o     (cur_loc),
    .str_o         (cur_str),
    .dec_in_data_i (dec_in_data),
    .dec_addr_i    (dec_addr),
    .dec_mask_i    (dec_mask),
    .buf_addr_o    (buf_addr_o),
    .buf_rd_en_o   (buf_rd_en_o),
    .buf_rdata_i   (buf_rdata_i),
    .buf_wr_en_o   (buf_wr_en_o),
    .buf_wdata_o   (buf_wdata_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .erased_o      (erased_o),
    .overflow_o    (overflow_o)
  );

  // A list entry naming a parity bit must never reach the buffer.
  assert_parity_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (cur_loc < LOC_W'(parity_bit_len(cur_str)))) |-> !buf_rd_en_o);

  // An erased sector sees no buffer traffic for the whole job.
  assert_erased_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && erased_o) |-> (!buf_rd_en_o && !buf_wr_en_o));

endmodule

// File: tb/bch_sector_fixer_tb.sv
`timescale 1ns/1ps
module bch_sector_fixer_tb;

  localparam int NLOC = 8;
  localparam int LW   = 13;
  localparam int PB   = 26;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [3:0]     cnt = '0;
  logic [NLOC*LW-1:0] locs = '0;
  logic [1:0]     str = '0;
  logic [PB*8-1:0] par = '0;
  logic [8:0]     addr;
  logic           rd_en, wr_en, busy, done, erased, ovf;
  logic [7:0]     rdata, wdata;

  logic [7:0] mem     [512];
  logic [7:0] exp_mem [512];
  int         rd_log  [16];
  int         rd_n;
  bit         log_clr = 1'b0;
  int         locs_t  [NLOC];
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  bch_sector_fixer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .err_count_i(cnt),
    .err_locs_i(locs), .strength_i(str), .parity_i(par),
    .buf_addr_o(addr), .buf_rd_en_o(rd_en), .buf_rdata_i(rdata),
    .buf_wr_en_o(wr_en), .buf_wdata_o(wdata), .busy_o(busy),
    .done_o(done), .erased_o(erased), .overflow_o(ovf)
  );

  // Sector buffer model with one-cycle read latency, plus read-address log
  always @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
    if (log_clr) rd_n <= 0;
    else if (rd_en) begin
      if (rd_n < 16) rd_log[rd_n] <= int'(addr);
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pbits_of(input logic [1:0] s);
    return (s == 2'd0) ? 52 : (s == 2'd2) ? 208 : 104;
  endfunction

  function automatic logic [PB*8-1:0] erased_par(input int nbytes);
    logic [PB*8-1:0] p = '0;
    for (int k = 0; k < nbytes - 1; k++) p[k*8 +: 8] = 8'hFF;
    return p;
  endfunction

  task automatic run_job(input string req, input logic [1:0] s, input int count,
                         input logic [PB*8-1:0] pv, input bit exp_er, input bit poke);
    int P = pbits_of(s);
    int clamp = (count > 8) ? 8 : count;
    int nrd = 0;
    int ncyc = 0;
    int lat;
    int exp_ord [8];
    int bad_bytes = 0;
    int first_bad = 0;
    bit extra_done = 1'b0;
    int rd_at_done;
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'((i * 37 + 11) & 255);
      exp_mem[i] = 8'((i * 37 + 11) & 255);
    end
    for (int k = 0; k < clamp; k++) begin
      int L = locs_t[k];
      if (!exp_er && L >= P && (L - P) < 4096) begin
        int a = L - P;
        int b = (4095 - a) / 8;
        exp_mem[b] = exp_mem[b] ^ 8'(1 << (a % 8));
        exp_ord[nrd] = b;
        nrd++;
        ncyc += 2;
      end else begin
        ncyc += 1;
      end
    end
    if (exp_er) begin nrd = 0; ncyc = 0; end
    @(negedge clk);
    log_clr = 1'b1;
    for (int k = 0; k < NLOC; k++) locs[k*LW +: LW] = LW'(locs_t[k]);
    cnt = 4'(count); str = s; par = pv;
    @(negedge clk);
    log_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (poke && lat == 2) begin
        start = 1'b1; cnt = 4'd8;
        for (int k = 0; k < NLOC; k++) locs[k*LW +: LW] = LW'(P + 8 * k);
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(done, req, "done seen", int'(done), 1);
    chk(lat == ((exp_er || clamp == 0) ? 1 : ncyc + 1), "R6", "done latency", lat,
        (exp_er || clamp == 0) ? 1 : ncyc + 1);
    chk(erased == exp_er, "R5", "erased flag", int'(erased), int'(exp_er));
    chk(ovf == (count > 8), "R7", "overflow flag", int'(ovf), int'(count > 8));
    rd_at_done = rd_n;
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      if (done || rd_en || wr_en) extra_done = 1'b1;
    end
    chk(!extra_done, "R8", "quiet after done", int'(extra_done), 0);
    chk(rd_n == nrd && rd_at_done == nrd, req, "buffer read count", rd_n, nrd);
    for (int k = 0; k < nrd && k < 8; k++)
      chk(rd_log[k] == exp_ord[k], "R6", "read order address", rd_log[k], exp_ord[k]);
    for (int i = 0; i < 512; i++)
      if (mem[i] !== exp_mem[i]) begin
        if (bad_bytes == 0) first_bad = i;
        bad_bytes++;
      end
    chk(bad_bytes == 0, req, "sector bytes differing (first index reported)", first_bad, -1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !erased && !ovf, "R1", "reset outputs",
        int'({busy, done, erased, ovf}), 0);
    chk(!rd_en && !wr_en, "R1", "reset strobes", int'({rd_en, wr_en}), 0);
  endtask

  task automatic t_mixed();
    // R3, R4: parity entries interleaved with data entries, strength 8
    locs_t = '{50, 104, 300, 0, 4199, 103, 2000, 1500};
    run_job("R4", 2'd1, 8, '0, 1'b0, 1'b0);
  endtask

  task automatic t_str4();
    // R2: 52 parity bits; 52 maps to byte 511 bit 0, 51 is parity
    locs_t = '{51, 52, 59, 60, 0, 0, 0, 0};
    run_job("R2", 2'd0, 4, '0, 1'b0, 1'b0);
  endtask

  task automatic t_str16();
    // R2: 208 parity bits; 208+4095 maps to byte 0 bit 7
    locs_t = '{207, 208 + 4095, 208, 1000, 0, 0, 0, 0};
    run_job("R2", 2'd2, 4, '0, 1'b0, 1'b0);
  endtask

  task automatic t_str3();
    // R2: code 3 treated as code 1
    locs_t = '{103, 104, 200, 0, 0, 0, 0, 0};
    run_job("R2", 2'd3, 3, '0, 1'b0, 1'b0);
  endtask

  task automatic t_erased();
    logic [PB*8-1:0] p;
    // R5: first 13 of 14 bytes 0xFF, last byte 0x00 -> erased
    locs_t = '{200, 300, 400, 500, 0, 0, 0, 0};
    run_job("R5", 2'd1, 4, erased_par(14), 1'b1, 1'b0);
    // R5: strength 0 checks only 7 bytes
    run_job("R5", 2'd0, 4, erased_par(8), 1'b1, 1'b0);
    // R5: one checked byte not 0xFF -> corrections applied
    p = erased_par(14);
    p[12*8 +: 8] = 8'hFE;
    run_job("R5", 2'd1, 4, p, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    // R7: 12 requested, only 8 used
    locs_t = '{110, 120, 130, 140, 150, 160, 170, 180};
    run_job("R7", 2'd1, 12, '0, 1'b0, 1'b0);
  endtask

  task automatic t_zero();
    // R10: no entries
    locs_t = '{200, 300, 0, 0, 0, 0, 0, 0};
    run_job("R10", 2'd1, 0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_outside();
    // R9: beyond the codeword end is skipped
    locs_t = '{104 + 4096, 104 + 5000, 104 + 4095, 0, 0, 0, 0, 0};
    run_job("R9", 2'd1, 3, '0, 1'b0, 1'b0);
  endtask

  task automatic t_double();
    // R4: same bit twice restores the byte, proving write-back then re-read
    locs_t = '{500, 500, 501, 0, 0, 0, 0, 0};
    run_job("R4", 2'd1, 3, '0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start();
    // R8: a second start during the job is ignored
    locs_t = '{300, 400, 500, 600, 0, 0, 0, 0};
    run_job("R8", 2'd1, 4, '0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_str4();
    t_str16();
    t_str3();
    t_erased();
    t_overflow();
    t_zero();
    t_outside();
    t_double();
    t_busy_start();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule